// File: doc/BRIEF.md
# Packed 4:2:2 Video Pixel Unpacker

This block takes a stream of 32-bit words, each carrying two luma samples and one chroma pair of packed 4:2:2 video, and turns every word into two pixels on consecutive cycles. Each output pixel has its own luma value and carries the chroma pair that the word holds. A 2-bit order code says where each of the four bytes sits in the word. The code names the components starting from the most significant byte. A stream that is conventionally named in memory order therefore takes the mirrored code.

A line-length setting, given in bits (the byte pitch times 8), sets how many words make up one line. The second pixel of the last word in a line carries an end-of-line flag. An enable input gates the whole block. When it is low, no word is taken, no pixel comes out, and any half-finished word and line position are dropped. Only one layer at a time is expected to route through this path. Upstream logic sends every other layer down the RGB path.

Top module: `yuv422_unpack`

## Requirements
- R1: After reset, out_valid and out_eol are low. The first word accepted after reset starts a new line.
- R2: in_ready is high exactly when cfg_en is high and no second pixel of an earlier word is still waiting to be emitted. A word is accepted on a rising edge where in_valid and in_ready are both high.
- R3: An accepted word produces its first pixel on the cycle after acceptance and its second pixel on the cycle after that, both with out_valid high. The first pixel's luma is the one in the lower-addressed byte lane of the pair.
- R4: Luma placement: for cfg_seq 00 and 10, the first luma is bits [15:8] and the second is bits [31:24]. For cfg_seq 01 and 11, the first luma is bits [7:0] and the second is bits [23:16].
- R5: Chroma placement: chroma occupies the two byte lanes that luma does not. When cfg_seq[1] is 0, the higher of those two lanes is U and the lower is V. When cfg_seq[1] is 1, the higher lane is V and the lower lane is U. The full mapping, listed from bits [31:24] down to [7:0], is: 00 = Y1 U Y0 V, 01 = U Y1 V Y0, 10 = Y1 V Y0 U, 11 = V Y1 U Y0.
- R6: Both pixels of a word carry the same U and V values.
- R7: With cfg_line_bits / 32 = N (N >= 1), out_eol is high only on the second pixel of the N-th word of a line. The next word accepted starts a new line.
- R8: A cfg_line_bits value below 32 counts as a one-word line, so every word ends a line.
- R9: While cfg_en is low, no word is accepted and out_valid stays low from the next cycle onward. A pending second pixel is discarded. The first word accepted after the block is enabled again starts a new line.
- R10: While in_ready is low, the value on in_data and in_valid has no effect on any output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable |
| cfg_seq | input | 2 | Byte-order code, named from the most significant byte |
| cfg_line_bits | input | LINE_W | Line length in bits |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Packed 4:2:2 word |
| in_ready | output | 1 | Block takes a word this cycle |
| out_valid | output | 1 | Pixel present on the outputs |
| out_y | output | 8 | Luma of the pixel |
| out_u | output | 8 | Blue-difference chroma |
| out_v | output | 8 | Red-difference chroma |
| out_eol | output | 1 | Last pixel of the line |

## Verification
The assertions assume that cfg_seq and cfg_line_bits do not change while a word is half emitted. They also assume that the consumer takes every pixel the cycle it appears, since the output has no back-pressure. The stimulus changes the configuration only when no pixel is pending, or while the enable is low. It drops the enable in the middle of a word on purpose, to check the discard behaviour. Stalled cycles feed changing data with in_valid toggling, so that any leak of an ignored word would show up at the pixel outputs.

// File: rtl/yuv422_pkg.sv
package yuv422_pkg;
    localparam int unsigned COMP_W  = 8;
    localparam int unsigned LANES   = 4;
    localparam int unsigned WORD_W  = COMP_W * LANES;

    typedef struct packed {
        logic              out_valid;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] u;
        logic [COMP_W-1:0] v;
        logic              eol;
        logic              pend;
        logic [COMP_W-1:0] pend_y;
        logic              pend_last;
    } unpack_state_t;
endpackage

// File: rtl/yuv422_lane_sel.sv
module yuv422_lane_sel
    import yuv422_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        seq,
    output logic [COMP_W-1:0] y0,
    output logic [COMP_W-1:0] y1,
    output logic [COMP_W-1:0] u,
    output logic [COMP_W-1:0] v
);
    logic [COMP_W-1:0] lane [LANES];
    logic [COMP_W-1:0] c_lo, c_hi;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[i*COMP_W +: COMP_W];
    end

    always_comb begin
        // seq[0]: luma in even lanes; seq[1]: higher chroma lane is V
        if (seq[0]) begin
            y0   = lane[0];
            y1   = lane[2];
            c_lo = lane[1];
            c_hi = lane[3];
        end else begin
            y0   = lane[1];
            y1   = lane[3];
            c_lo = lane[0];
            c_hi = lane[2];
        end
        u = seq[1] ? c_lo : c_hi;
        v = seq[1] ? c_hi : c_lo;
    end
endmodule

// File: rtl/yuv422_line_ctr.sv
module yuv422_line_ctr #(
    parameter int unsigned LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [LINE_W-1:0] line_bits,
    output logic              last
);
    localparam int unsigned SHIFT = $clog2(yuv422_pkg::WORD_W);
    localparam int unsigned CNT_W = LINE_W - SHIFT;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   next_cnt;

    assign limit    = line_bits[LINE_W-1:SHIFT];
    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign last     = next_cnt >= {1'b0, limit};

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (advance)
            cnt_d = last ? '0 : next_cnt[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && advance && last) |=> (cnt_q == '0));
endmodule

// File: rtl/yuv422_unpack.sv
module yuv422_unpack
    import yuv422_pkg::*;
#(
    parameter int unsigned LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_seq,
    input  logic [LINE_W-1:0] cfg_line_bits,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_y,
    output logic [7:0]        out_u,
    output logic [7:0]        out_v,
    output logic              out_eol
);
    unpack_state_t st_d, st_q;
    logic [COMP_W-1:0] w_y0, w_y1, w_u, w_v;
    logic              line_last;
    logic              fire;

    assign in_ready = cfg_en && !st_q.pend;
    assign fire     = in_valid && in_ready;

    yuv422_lane_sel u_lane_sel (
        .word (in_data),
        .seq  (cfg_seq),
        .y0   (w_y0),
        .y1   (w_y1),
        .u    (w_u),
        .v    (w_v)
    );

    yuv422_line_ctr #(.LINE_W(LINE_W)) u_line_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!cfg_en),
        .advance   (fire),
        .line_bits (cfg_line_bits),
        .last      (line_last)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.eol       = 1'b0;
        if (!cfg_en) begin
            st_d = '0;
        end else if (st_q.pend) begin
            st_d.out_valid = 1'b1;
            st_d.y         = st_q.pend_y;
            st_d.eol       = st_q.pend_last;
            st_d.pend      = 1'b0;
        end else if (in_valid) begin
            st_d.out_valid = 1'b1;
            st_d.y         = w_y0;
            st_d.u         = w_u;
            st_d.v         = w_v;
            st_d.pend      = 1'b1;
            st_d.pend_y    = w_y1;
            st_d.pend_last = line_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_y     = st_q.y;
    assign out_u     = st_q.u;
    assign out_v     = st_q.v;
    assign out_eol   = st_q.eol;

    // R3
    first_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (out_valid && !out_eol));

    // R2
    hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !in_ready);

    // R6
    shared_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire ##1 cfg_en) |=> (out_valid && $stable(out_u) && $stable(out_v)));

    // R7
    eol_with_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    // R9
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !out_valid);
endmodule

// File: tb/yuv422_unpack_tb.sv
`timescale 1ns/1ps
module yuv422_unpack_tb;
    localparam int LINE_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [1:0] cfg_seq = 2'b00;
    logic [LINE_W-1:0] cfg_line_bits = '0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, out_valid, out_eol;
    logic [7:0] out_y, out_u, out_v;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int line_pos = 0;
    logic [24:0] expq [$];

    always #2.5 clk = ~clk;

    yuv422_unpack #(.LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_seq(cfg_seq),
        .cfg_line_bits(cfg_line_bits), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_y(out_y),
        .out_u(out_u), .out_v(out_v), .out_eol(out_eol)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic decode(input logic [31:0] w, input logic [1:0] s,
                          output logic [7:0] y0, output logic [7:0] y1,
                          output logic [7:0] u, output logic [7:0] v);
        case (s)
            2'b00: begin y1 = w[31:24]; u  = w[23:16]; y0 = w[15:8]; v  = w[7:0]; end
            2'b01: begin u  = w[31:24]; y1 = w[23:16]; v  = w[15:8]; y0 = w[7:0]; end
            2'b10: begin y1 = w[31:24]; v  = w[23:16]; y0 = w[15:8]; u  = w[7:0]; end
            default: begin v = w[31:24]; y1 = w[23:16]; u = w[15:8]; y0 = w[7:0]; end
        endcase
    endtask

    // one clock: drive at the falling edge, compare after the next rising edge
    task automatic tick(input string tag, input logic v, input logic [31:0] d);
        logic exp_ready;
        logic [7:0] y0, y1, u, cv;
        int lim;
        logic last;
        logic [24:0] e;
        in_valid = v;
        in_data  = d;
        if (!cfg_en) begin
            expq.delete();
            line_pos = 0;
        end
        #0.1;
        exp_ready = cfg_en && (expq.size() == 0);
        check(tag, "in_ready", int'(in_ready), int'(exp_ready));
        if (v && exp_ready) begin
            decode(d, cfg_seq, y0, y1, u, cv);
            lim  = int'(cfg_line_bits) / 32;
            last = (line_pos + 1 >= lim);
            line_pos = last ? 0 : line_pos + 1;
            expq.push_back({1'b0, y0, u, cv});
            expq.push_back({last, y1, u, cv});
        end
        @(posedge clk);
        @(negedge clk);
        if (expq.size() > 0) begin
            e = expq.pop_front();
            check(tag, "out_valid", int'(out_valid), 1);
            check(tag, "out_y", int'(out_y), int'(e[23:16]));
            check(tag, "out_u", int'(out_u), int'(e[15:8]));
            check(tag, "out_v", int'(out_v), int'(e[7:0]));
            check(tag, "out_eol", int'(out_eol), int'(e[24]));
        end else begin
            check(tag, "out_valid", int'(out_valid), 0);
            check(tag, "out_eol", int'(out_eol), 0);
        end
    endtask

    task automatic flush(input string tag);
        while (expq.size() > 0) tick(tag, 1'b0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_eol", int'(out_eol), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "in_ready off", int'(in_ready), 0);

        // R3 R4 R5 R6 R7: each order code, four-word lines, back to back
        cfg_en = 1'b1;
        cfg_line_bits = 16'd128;
        for (int s = 0; s < 4; s++) begin
            cfg_seq = 2'(s);
            for (int k = 0; k < 16; k++)
                tick((s[0] ? "R4" : "R5"), 1'b1, 32'h11223344 + 32'(k) * 32'h01030507 + 32'(s << 28));
            flush("R7");
        end

        // R10: gaps and data changes while stalled
        cfg_seq = 2'b10;
        cfg_line_bits = 16'd96 + 16'd7;
        for (int k = 0; k < 30; k++)
            tick("R10", (k % 3) != 1, $urandom());
        flush("R10");

        // R8: line shorter than one word
        cfg_seq = 2'b01;
        cfg_line_bits = 16'd8;
        for (int k = 0; k < 6; k++) tick("R8", 1'b1, $urandom());
        cfg_line_bits = 16'd0;
        for (int k = 0; k < 4; k++) tick("R8", 1'b1, $urandom());
        flush("R8");

        // R9: disable with a pixel pending, then restart the line
        cfg_seq = 2'b11;
        cfg_line_bits = 16'd96;
        tick("R9", 1'b1, 32'hA1B2C3D4);
        tick("R9", 1'b1, 32'hDEADBEEF);
        tick("R9", 1'b1, 32'h0F1E2D3C);
        cfg_en = 1'b0;
        for (int k = 0; k < 4; k++) tick("R9", 1'b1, $urandom());
        cfg_en = 1'b1;
        for (int k = 0; k < 12; k++) tick("R9", 1'b1, $urandom());
        flush("R9");

        // R1: reset mid-line restarts line position
        tick("R1", 1'b1, 32'h01020304);
        flush("R1");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        expq.delete();
        line_pos = 0;
        for (int k = 0; k < 8; k++) tick("R1", 1'b1, $urandom());
        flush("R1");

        finish_run();
    end
endmodule